// File: doc/BRIEF.md
# EEPROM and PHY Management Access Bridge

This block lets a host that only has byte-wide register access read and write two kinds of 16-bit storage. The first is a word-organised configuration EEPROM, reached through a plain request/acknowledge word port. The second is the register space of an Ethernet PHY, reached through an MDIO frame engine that the block contains. The host sets a target select, a 6-bit word or register address, and a 2-bit PHY address. It places write data in, or collects read data from, a pair of byte registers. It then raises a read, write or reload command bit. The command bits stay set until software clears them. A transaction starts only on a 0-to-1 change of a command bit.

A busy flag in the control byte is high for the whole access. When a read completes, the result is copied into the data bytes on the same clock edge that drops busy. A PHY that is built into the same chip can be selected with an input pin. While that pin is high, the low two PHY address bits are replaced by a fixed value.

Top module: `ee_phy_bridge`

## Requirements
- R1: After reset the control byte (offset 0xB) reads 0x00 and the address byte (offset 0xC) reads 0x40, which is PHY address bits 01 and word address 0.
- R2: Control bit 0 is read-only and reads 1 while an access is in progress, 0 otherwise. Control bits 7:6 always read 0, whatever value is written to them.
- R3: The command bits are never cleared by hardware: read (bit 2), write (bit 1) and reload (bit 5) read back as written after their access completes.
- R4: An access starts only on a 0-to-1 change of a command bit. Writing the control byte again with the bit still set starts nothing.
- R5: With bit 3 = 0, a read raises `ee_req` with `ee_we` = 0 and `ee_addr` equal to address byte bits 5:0. The returned word lands in offset 0xD (bits 7:0) and offset 0xE (bits 15:8).
- R6: An EEPROM write is issued only when bit 4 (write enable) is set. It carries `ee_wdata` = {0xE, 0xD}. With bit 4 clear, the command does nothing, busy never rises and the stored word is unchanged.
- R7: A rise of bit 5 issues one `ee_req` with `ee_reload` = 1 and leaves the data bytes unchanged.
- R8: A PHY access sends a 64-bit MDIO frame, most significant bit first, with bits launched while `mdc` is low. The frame is 32 ones, start 01, opcode 10 for read or 01 for write, a 5-bit PHY address {000, address byte bits 7:6}, a register address equal to address byte bits 4:0, turnaround 10 and 16 data bits.
- R9: On a PHY read, `mdio_oe` is high for the first 46 bits only. `mdio_i` is sampled on the `mdc` rising edges of bits 48 to 63, and those 16 bits are placed in the data bytes.
- R10: While `phy_internal` = 1, the PHY address bits 1:0 are forced to 01, both in the frame and in the read-back of offset 0xC. The stored value returns once the pin is low.
- R11: Bit 3 = 0 routes an access to the EEPROM port with no `mdc` activity. Bit 3 = 1 routes it to MDIO with no `ee_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host byte write strobe |
| reg_addr | input | 4 | Host register offset (0xB..0xE) |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Host read byte (combinational) |
| phy_internal | input | 1 | Built-in PHY selected; forces PHY address bits 1:0 |
| ee_req | output | 1 | EEPROM word request, held until acknowledged |
| ee_we | output | 1 | Request is a write |
| ee_reload | output | 1 | Request is a contents reload |
| ee_addr | output | 6 | EEPROM word address |
| ee_wdata | output | 16 | EEPROM write word |
| ee_ack | input | 1 | EEPROM request completed |
| ee_rdata | input | 16 | EEPROM read word, valid with `ee_ack` |
| mdc | output | 1 | MDIO clock |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data in |

## Verification
The bench looks for a command bit that gets cleared on completion. It looks for a second access started by rewriting a control byte that already holds a set command bit. It looks for a write that reaches the EEPROM with the enable bit low. Each of these shows up as a wrong control read-back or an extra request seen by the EEPROM model. The MDIO side is checked bit for bit against a bench PHY that records every launched bit and its output-enable. A frame with a wrong opcode, a PHY address that ignores the forcing pin, or a turnaround that is not released would change that record. A read-data capture shifted by one edge would put the wrong word in the data bytes. A reload that overwrote the data bytes, or an access sent to the unselected target, would also be reported.

// File: rtl/epb_pkg.sv
package epb_pkg;
   localparam int FRAME_BITS = 64;
   localparam int DRIVE_RD   = 46;
   localparam int DATA_START = 48;
   localparam int WORD_W     = 16;
   localparam int EE_AW      = 6;

   typedef enum logic [1:0] {EE_RD = 2'd0, EE_WR = 2'd1, EE_RLD = 2'd2} ee_op_t;

   localparam logic [3:0] OFF_CTRL = 4'hB;
   localparam logic [3:0] OFF_ADDR = 4'hC;
   localparam logic [3:0] OFF_DLO  = 4'hD;
   localparam logic [3:0] OFF_DHI  = 4'hE;

   function automatic logic [FRAME_BITS-1:0] mdio_frame(input logic rd,
                                                        input logic [4:0] phy,
                                                        input logic [4:0] rg,
                                                        input logic [WORD_W-1:0] wd);
      return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
   endfunction
endpackage

// File: rtl/epb_ee_port.sv
module epb_ee_port
   import epb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  ee_op_t            op,
   input  logic [EE_AW-1:0]  word,
   input  logic [WORD_W-1:0] wdata,
   output logic              ee_req,
   output logic              ee_we,
   output logic              ee_reload,
   output logic [EE_AW-1:0]  ee_addr,
   output logic [WORD_W-1:0] ee_wdata,
   input  logic              ee_ack,
   input  logic [WORD_W-1:0] ee_rdata,
   output logic              done,
   output logic [WORD_W-1:0] rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ee_req    <= 1'b0;
         ee_we     <= 1'b0;
         ee_reload <= 1'b0;
         ee_addr   <= '0;
         ee_wdata  <= '0;
      end else if (start && !ee_req) begin
         ee_req    <= 1'b1;
         ee_we     <= (op == EE_WR);
         ee_reload <= (op == EE_RLD);
         ee_addr   <= word;
         ee_wdata  <= wdata;
      end else if (ee_req && ee_ack) begin
         ee_req    <= 1'b0;
         ee_we     <= 1'b0;
         ee_reload <= 1'b0;
      end
   end

   assign done  = ee_req && ee_ack;
   assign rdata = ee_rdata;

   // R5: a pending request keeps its address until acknowledged
   p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ee_req && !ee_ack |=> ee_req && $stable(ee_addr));
endmodule

// File: rtl/epb_mdio_engine.sv
module epb_mdio_engine
   import epb_pkg::*;
#(
   parameter int MDC_HALF = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_rd,
   input  logic [4:0]        phy,
   input  logic [4:0]        rg,
   input  logic [WORD_W-1:0] wdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i,
   output logic              active,
   output logic              done,
   output logic [WORD_W-1:0] rdata
);
   localparam int DIV_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

   logic [FRAME_BITS-1:0] shreg;
   logic [5:0]            bit_idx;
   logic [DIV_W-1:0]      div;
   logic                  rd_op;
   logic [WORD_W-1:0]     rsh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         done    <= 1'b0;
         mdc     <= 1'b0;
         shreg   <= '0;
         bit_idx <= '0;
         div     <= '0;
         rd_op   <= 1'b0;
         rsh     <= '0;
      end else begin
         done <= 1'b0;
         if (start && !active) begin
            active  <= 1'b1;
            shreg   <= mdio_frame(is_rd, phy, rg, wdata);
            rd_op   <= is_rd;
            bit_idx <= '0;
            div     <= '0;
            mdc     <= 1'b0;
         end else if (active) begin
            if (div == DIV_W'(MDC_HALF - 1)) begin
               div <= '0;
               if (!mdc) begin
                  mdc <= 1'b1;
                  if (rd_op && bit_idx >= 6'(DATA_START))
                     rsh <= {rsh[WORD_W-2:0], mdio_i};
               end else begin
                  mdc <= 1'b0;
                  if (bit_idx == 6'(FRAME_BITS - 1)) begin
                     active <= 1'b0;
                     done   <= 1'b1;
                  end else begin
                     bit_idx <= bit_idx + 6'd1;
                     shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                  end
               end
            end else begin
               div <= div + DIV_W'(1);
            end
         end
      end
   end

   assign mdio_o  = shreg[FRAME_BITS-1];
   assign mdio_oe = active && (!rd_op || bit_idx < 6'(DRIVE_RD));
   assign rdata   = rsh;

   // R11: clock stays low when no frame runs
   p_mdc_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !mdc);
   // R9: only a read gives up the line mid-frame
   p_oe_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
      active && $fell(mdio_oe) |-> rd_op);
   // R8: a frame ends only after its last bit
   p_frame_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bit_idx) == 6'(FRAME_BITS - 1));
endmodule

// File: rtl/epb_regs.sv
module epb_regs
   import epb_pkg::*;
#(
   parameter logic [1:0] RST_PHY_ADR = 2'b01,
   parameter logic [1:0] INT_PHY_ADR = 2'b01
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              phy_force,
   output logic              ee_start,
   output ee_op_t            ee_op,
   output logic [EE_AW-1:0]  word,
   output logic [WORD_W-1:0] wdata,
   input  logic              ee_done,
   input  logic [WORD_W-1:0] ee_rdata,
   output logic              mi_start,
   output logic              mi_rd,
   output logic [4:0]        mi_phy,
   input  logic              mi_done,
   input  logic [WORD_W-1:0] mi_rdata
);
   logic c_rld, c_wen, c_sel, c_rd, c_wr;
   logic p_rld, p_rd, p_wr;
   logic busy, busy_rd;
   logic [1:0] phy2, phy_eff;
   logic [7:0] dlo, dhi;
   logic rd_rise, wr_rise, rld_rise, wr_ctrl, wr_data;

   assign rd_rise  = c_rd  & ~p_rd;
   assign wr_rise  = c_wr  & ~p_wr;
   assign rld_rise = c_rld & ~p_rld;
   assign phy_eff  = phy_force ? INT_PHY_ADR : phy2;
   assign wr_ctrl  = reg_wr && (reg_addr == OFF_CTRL);
   assign wr_data  = reg_wr && (reg_addr == OFF_DLO || reg_addr == OFF_DHI);

   always_comb begin
      ee_start = 1'b0;
      ee_op    = EE_RD;
      mi_start = 1'b0;
      mi_rd    = 1'b0;
      if (!busy) begin
         if (rld_rise) begin
            ee_start = 1'b1;
            ee_op    = EE_RLD;
         end else if (rd_rise) begin
            if (c_sel) begin
               mi_start = 1'b1;
               mi_rd    = 1'b1;
            end else begin
               ee_start = 1'b1;
            end
         end else if (wr_rise) begin
            if (c_sel) begin
               mi_start = 1'b1;
            end else if (c_wen) begin
               ee_start = 1'b1;
               ee_op    = EE_WR;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {c_rld, c_wen, c_sel, c_rd, c_wr} <= '0;
         {p_rld, p_rd, p_wr}               <= '0;
         busy    <= 1'b0;
         busy_rd <= 1'b0;
         phy2    <= RST_PHY_ADR;
         word    <= '0;
         dlo     <= '0;
         dhi     <= '0;
      end else begin
         p_rld <= c_rld;
         p_rd  <= c_rd;
         p_wr  <= c_wr;
         if (wr_ctrl) {c_rld, c_wen, c_sel, c_rd, c_wr} <= reg_wdata[5:1];
         if (reg_wr && reg_addr == OFF_ADDR) {phy2, word} <= reg_wdata;
         if (reg_wr && reg_addr == OFF_DLO) dlo <= reg_wdata;
         if (reg_wr && reg_addr == OFF_DHI) dhi <= reg_wdata;
         if (ee_start || mi_start) begin
            busy    <= 1'b1;
            busy_rd <= mi_rd || (ee_start && ee_op == EE_RD);
         end else if (busy && (ee_done || mi_done)) begin
            busy <= 1'b0;
            if (busy_rd) {dhi, dlo} <= ee_done ? ee_rdata : mi_rdata;
         end
      end
   end

   always_comb begin
      case (reg_addr)
         OFF_CTRL: reg_rdata = {2'b00, c_rld, c_wen, c_sel, c_rd, c_wr, busy};
         OFF_ADDR: reg_rdata = {phy_eff, word};
         OFF_DLO:  reg_rdata = dlo;
         OFF_DHI:  reg_rdata = dhi;
         default:  reg_rdata = 8'h00;
      endcase
   end

   assign wdata  = {dhi, dlo};
   assign mi_phy = {3'b000, phy_eff};

   // R2: a launched access is flagged busy on the next cycle
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_start || mi_start) |=> busy);
   // R3: command bits change only by host write
   p_cmd_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable({c_rld, c_wen, c_sel, c_rd, c_wr}));
   // R7: a non-read access leaves the data bytes alone
   p_nord_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !busy_rd && !wr_data |=> $stable({dhi, dlo}));
   // R6: an EEPROM write is never launched while writes are disabled
   p_we_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ee_start && ee_op == EE_WR |-> c_wen);
endmodule

// File: rtl/ee_phy_bridge.sv
module ee_phy_bridge
   import epb_pkg::*;
#(
   parameter int         MDC_HALF    = 2,
   parameter bit         HAS_INT_PHY = 1'b1,
   parameter logic [1:0] RST_PHY_ADR = 2'b01,
   parameter logic [1:0] INT_PHY_ADR = 2'b01
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [3:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        phy_internal,
   output logic        ee_req,
   output logic        ee_we,
   output logic        ee_reload,
   output logic [5:0]  ee_addr,
   output logic [15:0] ee_wdata,
   input  logic        ee_ack,
   input  logic [15:0] ee_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   generate
      if (MDC_HALF < 1) begin : g_bad_div
         $error("MDC_HALF must be at least 1");
      end
   endgenerate

   logic phy_force;
   generate
      if (HAS_INT_PHY) begin : g_int_phy
         assign phy_force = phy_internal;
      end else begin : g_ext_only
         assign phy_force = 1'b0;
      end
   endgenerate

   ee_op_t            ee_op;
   logic              ee_start, ee_done, mi_start, mi_rd, mi_done, mi_active;
   logic [EE_AW-1:0]  word;
   logic [WORD_W-1:0] wdata, ee_rd_w, mi_rdata;
   logic [4:0]        mi_phy;

   epb_regs #(.RST_PHY_ADR(RST_PHY_ADR), .INT_PHY_ADR(INT_PHY_ADR)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phy_force(phy_force),
      .ee_start(ee_start), .ee_op(ee_op), .word(word), .wdata(wdata),
      .ee_done(ee_done), .ee_rdata(ee_rd_w), .mi_start(mi_start), .mi_rd(mi_rd),
      .mi_phy(mi_phy), .mi_done(mi_done), .mi_rdata(mi_rdata));

   epb_ee_port u_ee (
      .clk(clk), .rst_n(rst_n), .start(ee_start), .op(ee_op), .word(word),
      .wdata(wdata), .ee_req(ee_req), .ee_we(ee_we), .ee_reload(ee_reload),
      .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack),
      .ee_rdata(ee_rdata), .done(ee_done), .rdata(ee_rd_w));

   epb_mdio_engine #(.MDC_HALF(MDC_HALF)) u_mdio (
      .clk(clk), .rst_n(rst_n), .start(mi_start), .is_rd(mi_rd), .phy(mi_phy),
      .rg(word[4:0]), .wdata(wdata), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i), .active(mi_active), .done(mi_done),
      .rdata(mi_rdata));

   // R11: the two targets are never engaged together
   p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ee_req && mi_active));
endmodule

// File: tb/sim_ee_phy_bridge.sv
module sim_ee_phy_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'h0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        phy_internal = 1'b0;
   logic        ee_req, ee_we, ee_reload;
   logic [5:0]  ee_addr;
   logic [15:0] ee_wdata;
   logic        ee_ack = 1'b0;
   logic [15:0] ee_rdata;
   logic        mdc, mdio_o, mdio_oe, mdio_i;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   ee_phy_bridge u0 (.*);

   // EEPROM word model
   logic [15:0] mem [64];
   int ee_cnt = 0;
   int rld_cnt = 0;
   logic [5:0] last_addr = '0;
   initial for (int i = 0; i < 64; i++) mem[i] = 16'hA500 ^ (16'(i) * 16'h0101);
   assign ee_rdata = mem[ee_addr];
   always @(posedge clk) begin
      if (!rst_n) ee_ack <= 1'b0;
      else begin
         ee_ack <= ee_req && !ee_ack;
         if (ee_req && !ee_ack) begin
            ee_cnt    <= ee_cnt + 1;
            last_addr <= ee_addr;
            if (ee_we) mem[ee_addr] <= ee_wdata;
            if (ee_reload) rld_cnt <= rld_cnt + 1;
         end
      end
   end

   // PHY model: records every bit at mdc rise, answers reads
   logic [5:0]  phy_idx = '0;
   logic [63:0] cap = '0;
   logic [63:0] oem = '0;
   logic [15:0] phy_rd = 16'h0000;
   int mdc_cnt = 0;
   assign mdio_i = (phy_idx >= 6'd48) ? phy_rd[6'd63 - phy_idx] : 1'b1;
   always @(posedge mdc) begin
      cap[6'd63 - phy_idx] <= mdio_o;
      oem[6'd63 - phy_idx] <= mdio_oe;
      phy_idx <= phy_idx + 6'd1;
      mdc_cnt <= mdc_cnt + 1;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic host_read(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle(output bit saw);
      logic [7:0] d;
      saw = 1'b0;
      repeat (2) begin
         @(negedge clk); host_read(4'hB, d);
         if (d[0]) saw = 1'b1;
      end
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk); host_read(4'hB, d);
         if (!d[0]) break;
         saw = 1'b1;
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      host_read(4'hB, d); chk(d == 8'h00, "R1 ctrl reset", d, 8'h00);
      host_read(4'hC, d); chk(d == 8'h40, "R1 addr reset", d, 8'h40);
   endtask

   task automatic t_ee_read();
      logic [7:0] lo, hi, c;
      bit saw;
      int m0;
      m0 = mdc_cnt;
      host_write(4'hC, 8'h05);
      host_write(4'hB, 8'h04);
      wait_idle(saw);
      chk(saw, "R2 busy seen", 64'(saw), 1);
      host_read(4'hD, lo); host_read(4'hE, hi);
      chk({hi, lo} == mem[5], "R5 read data", {hi, lo}, mem[5]);
      chk(last_addr == 6'd5, "R5 word address", last_addr, 5);
      host_read(4'hB, c);
      chk(c == 8'h04, "R3 read cmd kept", c, 8'h04);
      chk(mdc_cnt == m0, "R11 no mdc on EEPROM op", mdc_cnt, m0);
   endtask

   task automatic t_edge_only();
      bit saw;
      int n0;
      n0 = ee_cnt;
      host_write(4'hB, 8'h04);
      wait_idle(saw);
      repeat (5) @(negedge clk);
      chk(ee_cnt == n0, "R4 rewrite no restart", ee_cnt, n0);
      host_write(4'hB, 8'h00);
      host_write(4'hB, 8'h04);
      wait_idle(saw);
      chk(ee_cnt == n0 + 1, "R4 new edge restarts", ee_cnt, n0 + 1);
   endtask

   task automatic t_ee_write();
      logic [7:0] lo, hi;
      logic [15:0] orig;
      bit saw;
      int n0;
      orig = mem[7];
      host_write(4'hB, 8'h00);
      host_write(4'hC, 8'h07);
      host_write(4'hD, 8'h34);
      host_write(4'hE, 8'h12);
      n0 = ee_cnt;
      host_write(4'hB, 8'h02);
      wait_idle(saw);
      chk(!saw, "R6 no busy without enable", 64'(saw), 0);
      chk(ee_cnt == n0, "R6 no request without enable", ee_cnt, n0);
      host_write(4'hB, 8'h00);
      host_write(4'hB, 8'h04);
      wait_idle(saw);
      host_read(4'hD, lo); host_read(4'hE, hi);
      chk({hi, lo} == orig, "R6 word unchanged", {hi, lo}, orig);
      host_write(4'hD, 8'h34);
      host_write(4'hE, 8'h12);
      host_write(4'hB, 8'h00);
      host_write(4'hB, 8'h12);
      wait_idle(saw);
      chk(saw, "R6 enabled write busy", 64'(saw), 1);
      host_write(4'hD, 8'h00);
      host_write(4'hE, 8'h00);
      host_write(4'hB, 8'h00);
      host_write(4'hB, 8'h04);
      wait_idle(saw);
      host_read(4'hD, lo); host_read(4'hE, hi);
      chk({hi, lo} == 16'h1234, "R6 written word", {hi, lo}, 16'h1234);
   endtask

   task automatic t_reload();
      logic [7:0] lo, hi, c;
      bit saw;
      int r0;
      host_write(4'hB, 8'h00);
      host_write(4'hD, 8'h5A);
      host_write(4'hE, 8'hC3);
      r0 = rld_cnt;
      host_write(4'hB, 8'h20);
      wait_idle(saw);
      chk(rld_cnt == r0 + 1, "R7 one reload", rld_cnt, r0 + 1);
      host_read(4'hD, lo); host_read(4'hE, hi);
      chk({hi, lo} == 16'hC35A, "R7 data untouched", {hi, lo}, 16'hC35A);
      host_read(4'hB, c);
      chk(c == 8'h20, "R3 reload cmd kept", c, 8'h20);
   endtask

   task automatic t_phy_write();
      bit saw;
      int n0;
      logic [63:0] exp;
      host_write(4'hB, 8'h00);
      host_write(4'hC, 8'hA5);
      host_write(4'hD, 8'hEF);
      host_write(4'hE, 8'hBE);
      n0 = ee_cnt;
      host_write(4'hB, 8'h0A);
      wait_idle(saw);
      exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'b00010, 5'b00101, 2'b10, 16'hBEEF};
      chk(cap == exp, "R8 write frame", cap, exp);
      chk(oem == 64'hFFFF_FFFF_FFFF_FFFF, "R8 write drives all", oem, 64'hFFFF_FFFF_FFFF_FFFF);
      chk(ee_cnt == n0, "R11 no ee_req on PHY op", ee_cnt, n0);
   endtask

   task automatic t_phy_read(input bit internal, input logic [4:0] exp_phy, input logic [15:0] val);
      logic [7:0] lo, hi;
      bit saw;
      phy_rd = val;
      host_write(4'hB, 8'h00);
      host_write(4'hB, 8'h0C);
      wait_idle(saw);
      chk(cap[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, exp_phy, 5'b00011},
          internal ? "R10 forced PHY address in frame" : "R8 read header",
          cap[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, exp_phy, 5'b00011});
      chk(oem == 64'hFFFF_FFFF_FFFC_0000, "R9 oe release", oem, 64'hFFFF_FFFF_FFFC_0000);
      host_read(4'hD, lo); host_read(4'hE, hi);
      chk({hi, lo} == val, "R9 read data", {hi, lo}, val);
   endtask

   task automatic t_reserved();
      logic [7:0] c;
      host_write(4'hB, 8'hC1);
      host_read(4'hB, c);
      chk(c == 8'h00, "R2 reserved and busy not writable", c, 8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ee_read();
      t_edge_only();
      t_ee_write();
      t_reload();
      t_phy_write();
      host_write(4'hC, 8'h03);
      t_phy_read(1'b0, 5'b00000, 16'h9C35);
      begin
         logic [7:0] a;
         host_write(4'hC, 8'hC3);
         phy_internal = 1'b1;
         @(negedge clk); host_read(4'hC, a);
         chk(a == 8'h43, "R10 forced readback", a, 8'h43);
         t_phy_read(1'b1, 5'b00001, 16'h6A17);
         phy_internal = 1'b0;
         @(negedge clk); host_read(4'hC, a);
         chk(a == 8'hC3, "R10 stored value returns", a, 8'hC3);
      end
      t_reserved();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule